// File: doc/BRIEF.md
# I2C Register-Bank Slave

This block lets an external I2C master read and write a bank of 8-bit registers inside the chip. A fast system clock oversamples SCL and SDA. The block finds START, repeated START and STOP conditions on the bus and shifts in address and data bytes. It answers with ACK or read data by enabling an open-drain pull-down on SDA. It never drives the line high.

The 7-bit device address is a fixed base of 0x42 plus a 2-bit strap value, which is captured only while reset is asserted. A write transfer carries a register-pointer byte and then any number of data bytes. A read transfer first sets the pointer with a write and then continues with a repeated START and the read address. After every data byte, read or written, the pointer steps by one. Inside a configurable hold window it stays fixed instead, so that queue-like or command-port registers can be streamed at one address. The general-call address is acknowledged but carries no register access.

The system clock must run at least ten times the SCL rate. Clock stretching and 10-bit addressing are not supported.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) is required before any byte is accepted; bytes clocked on the bus after reset without a START are never acknowledged.
- R2: A STOP (SDA rising while SCL is high) returns the slave to idle and ends a write; later bytes are ignored and not stored until a new START.
- R3: Bits are taken on SCL rising edges and transferred most significant bit first, in both directions.
- R4: The device answers to the 7-bit address 0x42 + strap_addr (write bytes 0x84, 0x86, 0x88, 0x8A for straps 0..3); strap_addr is captured only while rst_n is low, and later changes have no effect.
- R5: On an address match the slave pulls SDA low for the ninth clock; on a mismatch it does not acknowledge and stays silent, ignoring further bytes, until the next START.
- R6: In a write, the byte after the address sets the register pointer from its low 7 bits (bit 7 is ignored), and each following data byte is acknowledged and stored at the pointer.
- R7: A read is a pointer write, a repeated START and the address with R/W=1; the slave sends the register at the pointer and goes on with further bytes while the master acknowledges; after a master NACK it releases SDA (sda_oe=0).
- R8: Outside the hold window the pointer increments after every byte read or written, wrapping from 0x7F to 0x00.
- R9: Inside the hold window 0x60..0x6F (inclusive, parameters) the pointer stays fixed for the rest of the burst: written bytes overwrite the same register and reads repeat it.
- R10: The general-call address byte 0x00 is acknowledged; the bytes that follow are not acknowledged and change no register.
- R11: SDA is only ever pulled low, and sda_oe changes only while SCL is low.
- R12: After reset all registers read 0x00, the pointer is 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset; strap_addr is captured while low |
| strap_addr | input | 2 | Low two bits added to the device address base |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The directed cases target the points where a plausible design slips. A write burst crosses 0x7F; a design without wrap-around loses the third byte. A burst enters the hold window from 0x5F; a design that tests the window only at the burst start would spill into 0x61. The strap pins change after reset; a design that samples them continuously would answer to the wrong address. Further cases check that bytes after a STOP, a mismatched address or a general call are neither acknowledged nor stored, and that register-pointer bit 7 is dropped. Random bursts of writes and reads against a bench model cover the remaining pointer paths.

// File: rtl/i2c_rb_pkg.sv
// Shared types for the I2C register-bank slave.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package i2c_rb_pkg;

    // Bus engine states
    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for START, bus ignored
        ST_RX,        // shifting in a byte from the master
        ST_RX_END,    // byte taken, waiting for SCL low to drive ACK
        ST_ACK,       // ACK driven, waiting for SCL low to release
        ST_TX,        // shifting out a read byte
        ST_TX_WAIT,   // last bit out, waiting for SCL low to release
        ST_MACK,      // waiting for the master ACK/NACK bit
        ST_MACK_END   // master acked, waiting for SCL low to start next byte
    } bus_st_e;

    // What the byte being received means
    typedef enum logic [1:0] {
        RX_DEV,
        RX_PTR,
        RX_DATA
    } rx_kind_e;

    // What follows the ACK the slave is driving
    typedef enum logic [1:0] {
        AF_PTR,
        AF_DATA,
        AF_SEND,
        AF_DROP
    } after_ack_e;

endpackage

// File: rtl/i2c_rb_sync.sv
// Synchronises SCL and SDA into the system clock domain and derives
// edge and bus-condition pulses (START, STOP, SCL rise/fall).
// Assumes: system clock >= 10x SCL; idle bus level is high.
module i2c_rb_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Shift the raw lines through the synchroniser chains
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    // Keep the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[SYNC_STAGES-1];
            sda_q <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Decode levels, SCL edges and the SDA-while-SCL-high conditions
    always_comb begin
        scl_lvl   = scl_pipe[SYNC_STAGES-1];
        sda_lvl   = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end

endmodule

// File: rtl/i2c_rb_ptr_step.sv
// Computes the register pointer value after one byte: +1 with wrap,
// or unchanged when the pointer lies inside the hold window.
// Assumes: HOLD_LO/HOLD_HI are inclusive; HOLD_LO > HOLD_HI means no window.
module i2c_rb_ptr_step #(
    parameter int                ADDR_W  = 7,
    parameter logic [ADDR_W-1:0] HOLD_LO = 'h60,
    parameter logic [ADDR_W-1:0] HOLD_HI = 'h6F
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt,
    output logic              in_hold
);

    // Pick the window decode variant from the parameters
    generate
        if (HOLD_LO > HOLD_HI) begin : g_no_window
            assign in_hold = 1'b0;
        end else begin : g_window
            assign in_hold = (cur >= HOLD_LO) && (cur <= HOLD_HI);
        end
    endgenerate

    // Step or hold the pointer
    always_comb begin
        nxt = in_hold ? cur : cur + ADDR_W'(1);
    end

endmodule

// File: rtl/i2c_rb_regfile.sv
// Register bank: 2**ADDR_W bytes, one synchronous write port and one
// combinational read port, all bytes cleared by reset.
// Assumes: a single writer (the bus engine).
module i2c_rb_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, store one byte per write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    // Read the addressed byte
    assign rd_data = mem[addr];

endmodule

// File: rtl/i2c_rb_engine.sv
// I2C slave protocol engine: address match against a strapped device
// address, pointer byte, write bursts, read bursts with master ACK,
// general-call acknowledge. Drives SDA only through a pull-down enable.
// Assumes: inputs come from i2c_rb_sync; no clock stretching.
module i2c_rb_engine
    import i2c_rb_pkg::*;
#(
    parameter int         ADDR_W   = 7,
    parameter logic [6:0] DEV_BASE = 7'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_addr,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [7:0]        rd_data,
    input  logic [ADDR_W-1:0] ptr_nxt,
    input  logic              ptr_hold,
    output logic [ADDR_W-1:0] ptr,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              sda_oe
);

    bus_st_e    state;
    rx_kind_e   kind;
    after_ack_e after;
    logic [2:0] bit_cnt;
    logic [7:0] sh;
    logic [1:0] own_lo;
    logic [6:0] own_addr;
    logic [7:0] byte_in;
    logic       last_bit;
    logic       dev_hit;
    logic       gc_hit;

    // Decode the byte completing on this SCL rise and the address checks
    always_comb begin
        own_addr = DEV_BASE + {5'd0, own_lo};
        byte_in  = {sh[6:0], sda_lvl};
        last_bit = (bit_cnt == 3'd7);
        dev_hit  = (byte_in[7:1] == own_addr);
        gc_hit   = (byte_in == 8'h00);
        wr_en    = (state == ST_RX) && (kind == RX_DATA) && scl_rise && last_bit;
        wr_data  = byte_in;
    end

    // Protocol state machine, pointer register and SDA pull-down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= RX_DEV;
            after   <= AF_DROP;
            bit_cnt <= 3'd0;
            sh      <= 8'h00;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            own_lo  <= strap_addr;
        end else if (start_evt) begin
            state   <= ST_RX;
            kind    <= RX_DEV;
            bit_cnt <= 3'd0;
            sda_oe  <= 1'b0;
        end else if (stop_evt) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        sh      <= byte_in;
                        bit_cnt <= bit_cnt + 3'd1;
                        if (last_bit) begin
                            case (kind)
                                RX_DEV: begin
                                    if (dev_hit) begin
                                        state <= ST_RX_END;
                                        after <= byte_in[0] ? AF_SEND : AF_PTR;
                                    end else if (gc_hit) begin
                                        state <= ST_RX_END;
                                        after <= AF_DROP;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                RX_PTR: begin
                                    ptr   <= byte_in[ADDR_W-1:0];
                                    state <= ST_RX_END;
                                    after <= AF_DATA;
                                end
                                default: begin
                                    ptr   <= ptr_nxt;
                                    state <= ST_RX_END;
                                    after <= AF_DATA;
                                end
                            endcase
                        end
                    end
                end
                ST_RX_END: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= 3'd0;
                        case (after)
                            AF_PTR: begin
                                sda_oe <= 1'b0;
                                kind   <= RX_PTR;
                                state  <= ST_RX;
                            end
                            AF_DATA: begin
                                sda_oe <= 1'b0;
                                kind   <= RX_DATA;
                                state  <= ST_RX;
                            end
                            AF_SEND: begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_TX;
                            end
                            default: begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (last_bit) begin
                            ptr   <= ptr_nxt;
                            state <= ST_TX_WAIT;
                        end
                    end else if (scl_fall) begin
                        sh     <= {sh[6:0], 1'b0};
                        sda_oe <= ~sh[6];
                    end
                end
                ST_TX_WAIT: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        state <= sda_lvl ? ST_IDLE : ST_MACK_END;
                    end
                end
                ST_MACK_END: begin
                    if (scl_fall) begin
                        bit_cnt <= 3'd0;
                        sh      <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        state   <= ST_TX;
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_RX) && (kind == RX_DEV)); // R1

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE) && !sda_oe); // R2

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(own_lo)); // R4

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R5

    AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_hold) |=> ptr == $past(ptr) + ADDR_W'(1)); // R8

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr_hold) |=> ptr == $past(ptr)); // R9

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl); // R11

endmodule

// File: rtl/i2c_regbank_slave.sv
// Top of the I2C register-bank slave: synchroniser, protocol engine,
// pointer step logic and register bank.
// Assumes: clk >= 10x SCL; sda_oe drives an open-drain pull-down.
module i2c_regbank_slave #(
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] HOLD_LO     = 'h60,
    parameter logic [ADDR_W-1:0] HOLD_HI     = 'h6F,
    parameter logic [6:0]        DEV_BASE    = 7'h42,
    parameter int                SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_addr,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe
);

    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] ptr_nxt;
    logic              ptr_hold;
    logic              wr_en;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;

    i2c_rb_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2c_rb_engine #(
        .ADDR_W  (ADDR_W),
        .DEV_BASE(DEV_BASE)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_addr(strap_addr),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_data),
        .ptr_nxt   (ptr_nxt),
        .ptr_hold  (ptr_hold),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    i2c_rb_ptr_step #(
        .ADDR_W (ADDR_W),
        .HOLD_LO(HOLD_LO),
        .HOLD_HI(HOLD_HI)
    ) u_ptr (
        .cur    (ptr),
        .nxt    (ptr_nxt),
        .in_hold(ptr_hold)
    );

    i2c_rb_regfile #(
        .ADDR_W(ADDR_W),
        .DATA_W(8)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (ptr),
        .wr_data(wr_data),
        .rd_data(rd_data)
    );

endmodule

// File: tb/i2c_regbank_slave_test.sv
// Bench for i2c_regbank_slave: bit-level I2C master model, open-drain SDA,
// reference register model, directed corner cases plus seeded random bursts.
module i2c_regbank_slave_test;

    localparam int  Q     = 8;       // quarter SCL period in system clocks
    localparam logic [7:0] DEVW = 8'h88;
    localparam logic [7:0] DEVR = 8'h89;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap_addr = 2'b10;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_line;

    int vectors = 0;
    int miscompares = 0;
    int oe_bad = 0;
    bit done = 1'b0;
    logic [7:0] model [128];
    logic [7:0] wbuf [8];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regbank_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_addr(strap_addr),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe)
    );

    // Pointer step expected by the requirements (R8, R9)
    function automatic logic [6:0] step(input logic [6:0] p);
        if (p >= 7'h60 && p <= 7'h6F) return p;
        return p + 7'd1;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = (sda_line === 1'b0);
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q); scl_m = 1'b0;
        end
        tick(Q);
        send_bit(!give_ack);
        sda_m = 1'b1;
    endtask

    // Write burst of n bytes from wbuf starting at register byte regb
    task automatic xact_write(input logic [7:0] regb, input int n, input string req);
        logic ack;
        logic [6:0] p;
        bus_start;
        write_byte(DEVW, ack); check8("R5", {7'd0, ack}, 8'd1);
        write_byte(regb, ack); check8("R6", {7'd0, ack}, 8'd1);
        p = regb[6:0];
        for (int i = 0; i < n; i++) begin
            write_byte(wbuf[i], ack); check8(req, {7'd0, ack}, 8'd1);
            model[p] = wbuf[i];
            p = step(p);
        end
        bus_stop;
    endtask

    // Read burst of n bytes from register byte regb, NACK on the last
    task automatic xact_read(input logic [7:0] regb, input int n, input string req);
        logic ack;
        logic [6:0] p;
        logic [7:0] d;
        bus_start;
        write_byte(DEVW, ack); check8("R5", {7'd0, ack}, 8'd1);
        write_byte(regb, ack); check8("R6", {7'd0, ack}, 8'd1);
        bus_start;
        write_byte(DEVR, ack); check8("R7", {7'd0, ack}, 8'd1);
        p = regb[6:0];
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, d);
            check8(req, d, model[p]);
            p = step(p);
        end
        check8("R7", {7'd0, sda_oe}, 8'd0);
        bus_stop;
    endtask

    // R11: sda_oe may only change while SCL is low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_bad++;
        oe_prev <= sda_oe;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int seed_junk;
        seed_junk = $urandom(32'h5EED_1234);
        for (int i = 0; i < 128; i++) model[i] = 8'h00;

        tick(10);
        rst_n = 1'b1;
        tick(2);
        strap_addr = 2'b01;   // must be ignored from now on (R4)

        // R12: line released after reset
        check8("R12", {7'd0, sda_oe}, 8'd0);

        // R1: bytes without a START are not acknowledged
        scl_m = 1'b0; tick(Q);
        write_byte(DEVW, ack); check8("R1", {7'd0, ack}, 8'd0);
        bus_stop;

        // R12 / R4: read without setting the pointer starts at 0, regs cleared
        bus_start;
        write_byte(DEVR, ack); check8("R4", {7'd0, ack}, 8'd1);
        read_byte(1'b1, d); check8("R12", d, 8'h00);
        read_byte(1'b0, d); check8("R12", d, 8'h00);
        bus_stop;

        // R4: new strap value not taken; R5: mismatch stays silent
        bus_start;
        write_byte(8'h86, ack); check8("R4", {7'd0, ack}, 8'd0);
        bus_stop;
        bus_start;
        write_byte(8'h8A, ack); check8("R5", {7'd0, ack}, 8'd0);
        write_byte(8'h55, ack); check8("R5", {7'd0, ack}, 8'd0);
        bus_stop;

        // R8 wrap 0x7F -> 0x00, R3 bit order on read back
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        xact_write(8'h7E, 3, "R8");
        xact_read(8'h7E, 3, "R3");

        // R9: burst entering the hold window stays on 0x60
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        xact_write(8'h5F, 3, "R9");
        xact_read(8'h5F, 3, "R9");
        xact_read(8'h61, 1, "R9");

        // R6: bit 7 of the pointer byte is ignored
        wbuf[0] = 8'h5A;
        xact_write(8'h85, 1, "R6");
        xact_read(8'h05, 1, "R6");

        // R10: general call acknowledged, its payload dropped
        bus_start;
        write_byte(8'h00, ack); check8("R10", {7'd0, ack}, 8'd1);
        write_byte(8'h99, ack); check8("R10", {7'd0, ack}, 8'd0);
        bus_stop;
        xact_read(8'h00, 1, "R10");

        // R2: after STOP, bytes are ignored until a START
        wbuf[0] = 8'h44;
        xact_write(8'h10, 1, "R2");
        scl_m = 1'b0; tick(Q);
        write_byte(8'h77, ack); check8("R2", {7'd0, ack}, 8'd0);
        bus_stop;
        xact_read(8'h10, 2, "R2");

        // Random bursts around and away from the hold window
        for (int it = 0; it < 30; it++) begin
            logic [7:0] regb;
            int n;
            regb = ($urandom % 3 == 0) ? 8'(8'h5C + ($urandom % 24)) : 8'($urandom % 256);
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            if ($urandom % 2 == 0) xact_write(regb, n, "R8");
            else xact_read(regb, n, (regb[6:0] >= 7'h60 && regb[6:0] <= 7'h6F) ? "R9" : "R8");
        end

        // R11: pull-down enable never toggled with SCL high
        check8("R11", 8'(oe_bad), 8'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule